// File: doc/BRIEF.md
# Pull-in Range Guard

This block sits beside a PLL loop filter and decides how far that loop may chase its selected reference. Each cycle it takes the measured frequency offset of the reference. That offset is a signed count of ppb against the digitally calibrated free-run clock. The block compares the offset with a programmable pull-in limit and registers two status flags. The out-of-range flag reports that the reference lies beyond the pull-in window. The stopped flag reports that the loop has been held at the window edge instead of following the reference.

A policy input picks how the loop behaves out of range. In follow policy the steering target stays equal to the measured offset. In clamp policy the target saturates at the positive or negative limit. In self-timing mode there is no reference to chase, so the target is zero and the out-of-range flag stays low. A pull-in input masks the lock and sync indications while the loop re-acquires, for example after a reference switch or after recovery from signal or lock loss.

Top module: `pull_range_guard`

## Requirements
- R1: While rst_ni is low, oop_o, sap_o, lock_o, sync_o and target_o are all 0.
- R2: In external-timing mode (ext_mode_i=1), oop_o is 1 one cycle after the offset is above +limit or below -limit. An offset exactly equal to +limit or -limit counts as in range.
- R3: In self-timing mode (ext_mode_i=0), oop_o is 0 one cycle later, whatever the offset.
- R4: In clamp policy (clamp_en_i=1), sap_o equals oop_o for the same inputs.
- R5: In follow policy (clamp_en_i=0), sap_o is 0 one cycle later.
- R6: In external-timing mode, target_o is the offset registered one cycle later in two cases: follow policy, or an in-range offset.
- R7: In external-timing mode with clamp policy, target_o is +limit one cycle after an offset above +limit, and -limit one cycle after an offset below -limit.
- R8: In self-timing mode, target_o is 0 one cycle later.
- R9: lock_o and sync_o follow lock_raw_i and sync_raw_i one cycle later, and both are forced to 0 when pullin_i was 1.
- R10: With a limit of 0, any nonzero offset is out of range and an offset of 0 is in range.
- R11: The most negative offset, -2^23, is handled without overflow. With a limit of 2^23-1 it is out of range, and in clamp policy the target becomes -(2^23-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| offset_i | input | 24 | Signed reference offset in ppb, two's complement |
| limit_i | input | 24 | Unsigned pull-in limit in ppb |
| ext_mode_i | input | 1 | 1 = external timing, 0 = self timing |
| clamp_en_i | input | 1 | 1 = clamp at limit, 0 = follow reference |
| pullin_i | input | 1 | Pull-in in progress; masks lock and sync |
| lock_raw_i | input | 1 | Lock indication from the loop |
| sync_raw_i | input | 1 | Sync indication from the loop |
| oop_o | output | 1 | Reference outside pull-in range |
| sap_o | output | 1 | Loop held at pull-in boundary |
| target_o | output | 24 | Signed steering target in ppb |
| lock_o | output | 1 | Masked lock indication |
| sync_o | output | 1 | Masked sync indication |

## Verification
The bench concentrates on the window edges. An offset of exactly plus or minus the limit must stay in range, so an off-by-one comparator would raise the flag there. It also drives the most negative offset against the largest limit. A comparator or negation kept at 24 bits would wrap at that point, and the flag or the clamped target would come out with the wrong sign. A zero limit is exercised as well, because any nonzero offset must then trip the flag. Mode and policy changes are mixed with pull-in pulses: a missing mask would let lock through during re-acquisition, and a missing mode gate would raise the flag in self-timing mode.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic {POL_FOLLOW = 1'b0, POL_CLAMP = 1'b1} pr_policy_e;

  typedef struct packed {
    logic oop;
    logic sap;
    logic lock;
    logic sync;
  } pr_status_t;
endpackage

// File: rtl/pr_range_cmp.sv
module pr_range_cmp #(
  parameter int OW = 24,
  parameter int LW = 24
) (
  input  logic signed [OW-1:0] offset_i,
  input  logic        [LW-1:0] limit_i,
  output logic                 above_o,
  output logic                 below_o
);
  // guard bits keep -2^(OW-1) and -limit exact
  localparam int CW = ((OW > LW) ? OW : LW) + 2;

  logic signed [CW-1:0] ofs_x, lim_x, nlim_x;

  always_comb begin
    ofs_x   = CW'(offset_i);
    lim_x   = $signed({{(CW-LW){1'b0}}, limit_i});
    nlim_x  = -lim_x;
    above_o = ofs_x > lim_x;
    below_o = ofs_x < nlim_x;
  end
endmodule

// File: rtl/pr_target_sel.sv
module pr_target_sel #(
  parameter int OW = 24,
  parameter int LW = 24
) (
  input  logic signed [OW-1:0] offset_i,
  input  logic        [LW-1:0] limit_i,
  input  logic                 ext_mode_i,
  input  pr_pkg::pr_policy_e   policy_i,
  input  logic                 above_i,
  input  logic                 below_i,
  output logic signed [OW-1:0] target_o
);
  localparam int CW = ((OW > LW) ? OW : LW) + 2;

  logic signed [CW-1:0] lim_x, nlim_x;

  always_comb begin
    lim_x  = $signed({{(CW-LW){1'b0}}, limit_i});
    nlim_x = -lim_x;
    // limit below 2^(OW-1) whenever it saturates, so truncation is exact
    if (!ext_mode_i)
      target_o = '0;
    else if (policy_i == pr_pkg::POL_CLAMP && above_i)
      target_o = lim_x[OW-1:0];
    else if (policy_i == pr_pkg::POL_CLAMP && below_i)
      target_o = nlim_x[OW-1:0];
    else
      target_o = offset_i;
  end
endmodule

// File: rtl/pr_status_gen.sv
module pr_status_gen (
  input  logic               ext_mode_i,
  input  pr_pkg::pr_policy_e policy_i,
  input  logic               above_i,
  input  logic               below_i,
  input  logic               pullin_i,
  input  logic               lock_raw_i,
  input  logic               sync_raw_i,
  output pr_pkg::pr_status_t status_o
);
  always_comb begin
    status_o.oop  = ext_mode_i & (above_i | below_i);
    status_o.sap  = (policy_i == pr_pkg::POL_CLAMP) & status_o.oop;
    status_o.lock = lock_raw_i & ~pullin_i;
    status_o.sync = sync_raw_i & ~pullin_i;
  end
endmodule

// File: rtl/pull_range_guard.sv
module pull_range_guard #(
  parameter int OW = 24,
  parameter int LW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [OW-1:0] offset_i,
  input  logic        [LW-1:0] limit_i,
  input  logic                 ext_mode_i,
  input  logic                 clamp_en_i,
  input  logic                 pullin_i,
  input  logic                 lock_raw_i,
  input  logic                 sync_raw_i,
  output logic                 oop_o,
  output logic                 sap_o,
  output logic signed [OW-1:0] target_o,
  output logic                 lock_o,
  output logic                 sync_o
);
  import pr_pkg::*;

  pr_policy_e          policy;
  logic                above, below;
  logic signed [OW-1:0] target_d, target_q;
  pr_status_t          status_d, status_q;

  assign policy = clamp_en_i ? POL_CLAMP : POL_FOLLOW;

  pr_range_cmp #(.OW(OW), .LW(LW)) u_cmp (
    .offset_i (offset_i),
    .limit_i  (limit_i),
    .above_o  (above),
    .below_o  (below)
  );

  pr_target_sel #(.OW(OW), .LW(LW)) u_sel (
    .offset_i   (offset_i),
    .limit_i    (limit_i),
    .ext_mode_i (ext_mode_i),
    .policy_i   (policy),
    .above_i    (above),
    .below_i    (below),
    .target_o   (target_d)
  );

  pr_status_gen u_stat (
    .ext_mode_i (ext_mode_i),
    .policy_i   (policy),
    .above_i    (above),
    .below_i    (below),
    .pullin_i   (pullin_i),
    .lock_raw_i (lock_raw_i),
    .sync_raw_i (sync_raw_i),
    .status_o   (status_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      target_q <= '0;
    end else begin
      status_q <= status_d;
      target_q <= target_d;
    end
  end

  assign oop_o    = status_q.oop;
  assign sap_o    = status_q.sap;
  assign lock_o   = status_q.lock;
  assign sync_o   = status_q.sync;
  assign target_o = target_q;

  p_self_no_oop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ext_mode_i) |-> !oop_o);

  p_sap_needs_oop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sap_o |-> oop_o);

  p_follow_no_sap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clamp_en_i) |-> !sap_o);

  p_clamp_at_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sap_o |-> (target_o == $signed($past(limit_i[OW-1:0])) ||
               target_o == -$signed($past(limit_i[OW-1:0]))));

  p_self_zero_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ext_mode_i) |-> target_o == '0);

  p_pullin_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pullin_i) |-> (!lock_o && !sync_o));
endmodule

// File: tb/tb_pull_range_guard.sv
module tb_pull_range_guard;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [23:0] offset = '0;
  logic        [23:0] limit = '0;
  logic               ext_mode = 1'b0, clamp_en = 1'b0, pullin = 1'b0;
  logic               lock_raw = 1'b0, sync_raw = 1'b0;
  logic               oop, sap, lock, sync;
  logic signed [23:0] target;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pull_range_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .offset_i(offset), .limit_i(limit),
    .ext_mode_i(ext_mode), .clamp_en_i(clamp_en), .pullin_i(pullin),
    .lock_raw_i(lock_raw), .sync_raw_i(sync_raw),
    .oop_o(oop), .sap_o(sap), .target_o(target), .lock_o(lock), .sync_o(sync)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural model: integer arithmetic, result due one edge later
  task automatic step(string req, int ofs, int lim, bit ext, bit clp,
                      bit pin, bit lk, bit sy);
    longint o, l, e_tgt;
    bit     e_oop, e_sap;
    @(negedge clk);
    offset = ofs[23:0]; limit = lim[23:0];
    ext_mode = ext; clamp_en = clp; pullin = pin; lock_raw = lk; sync_raw = sy;
    o = longint'(offset);
    l = longint'({8'd0, limit});
    e_oop = ext && (o > l || o < -l);
    e_sap = clp && e_oop;
    if (!ext) e_tgt = 0;
    else if (clp && o > l) e_tgt = l;
    else if (clp && o < -l) e_tgt = -l;
    else e_tgt = o;
    @(posedge clk);
    @(negedge clk);
    chk(req, "oop", longint'(oop), longint'(e_oop));
    chk(req, "sap", longint'(sap), longint'(e_sap));
    chk(req, "target", longint'(target), e_tgt);
    chk(req, "lock", longint'(lock), longint'(lk && !pin));
    chk(req, "sync", longint'(sync), longint'(sy && !pin));
  endtask

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset holds outputs at zero despite active inputs
    offset = 24'sd5000; limit = 24'd10; ext_mode = 1; clamp_en = 1;
    lock_raw = 1; sync_raw = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "oop", longint'(oop), 0);
    chk("R1", "sap", longint'(sap), 0);
    chk("R1", "target", longint'(target), 0);
    chk("R1", "lock", longint'(lock), 0);
    chk("R1", "sync", longint'(sync), 0);
    rst_n = 1'b1;

    // R2: window edges, follow policy
    step("R2", 1000, 1000, 1, 0, 0, 1, 1);
    step("R2", 1001, 1000, 1, 0, 0, 1, 0);
    step("R2", -1000, 1000, 1, 0, 0, 0, 1);
    step("R2", -1001, 1000, 1, 0, 0, 1, 1);
    // R3 R8: self timing ignores offset
    step("R3", 900000, 5, 0, 1, 0, 1, 1);
    step("R8", -900000, 5, 0, 0, 0, 0, 0);
    // R4 R7: clamp policy saturates on both sides
    step("R7", 4000, 1500, 1, 1, 0, 1, 1);
    step("R7", -4000, 1500, 1, 1, 0, 1, 1);
    step("R4", 1500, 1500, 1, 1, 0, 1, 1);
    step("R4", -1501, 1500, 1, 1, 0, 0, 0);
    // R5 R6: follow policy passes offset through
    step("R5", 77777, 100, 1, 0, 0, 1, 1);
    step("R6", -77, 100, 1, 0, 0, 1, 1);
    // R9: pull-in masks lock and sync, then releases
    step("R9", 10, 100, 1, 1, 1, 1, 1);
    step("R9", 10, 100, 1, 1, 1, 0, 1);
    step("R9", 10, 100, 1, 1, 0, 1, 1);
    // R10: zero limit
    step("R10", 0, 0, 1, 1, 0, 1, 1);
    step("R10", 1, 0, 1, 1, 0, 1, 1);
    step("R10", -1, 0, 1, 0, 0, 1, 1);
    // R11: most negative offset against largest in-range limit
    step("R11", -8388608, 8388607, 1, 1, 0, 1, 1);
    step("R11", -8388608, 8388607, 1, 0, 0, 1, 1);
    step("R11", -8388608, 8388608, 1, 1, 0, 1, 1);
    step("R11", 8388607, 16777215, 1, 1, 0, 1, 1);

    // mixed patterns across all requirements
    for (int i = 0; i < 400; i++) begin
      int o, l;
      o = $signed($urandom_range(0, 32'h00FF_FFFF) << 8) >>> 8;
      l = int'($urandom_range(0, 3) == 0 ? $urandom_range(0, 32'h00FF_FFFF)
                                          : $urandom_range(0, 20000));
      if (i % 3 == 0) o = o % 30000;
      step("R2", o, l, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
           1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule